// File: doc/BRIEF.md
# Integer-Scaled VGA Output Generator

This block turns a 320x256 source image held in external memory into a 1280x1024 VGA picture driven from a 108 MHz pixel clock. It produces the horizontal and vertical sync pulses itself. Each source pixel is enlarged into a 4x4 square of output pixels, so the source resolution divides the screen exactly and needs no filtering.

The block does not store a whole source line. Once per output line, at the start of horizontal blanking, it sends a one-cycle request carrying the word address of the source line that the next output line shows. A memory arbiter outside the block answers by filling a first-word-fall-through line FIFO. The same source line is requested again for each of the four output lines it covers. During the active area the block pops one packed word per 12 output pixels. A word carries three 5-bit pixels. The block converts each pixel through a fixed palette to 4-bit red, green and blue levels, and drives black everywhere outside the active area.

A two-stage synchronizer releases the asynchronous active-low reset, so the raster starts on the third rising clock edge after the reset input goes high.

Top module: `scl_vga_out`

## Requirements
- R1: While `rst_ni` is low, every output is 0. The reset acts without a clock edge. After release, the first counted raster position (column 0 of line 0) reaches the registered outputs on the third rising edge.
- R2: A line lasts 1688 clocks: 1280 visible, 48 front porch, 112 sync, 248 back porch. `hsync_o` is active high during columns 1328 to 1439 and appears one clock after the column counter.
- R3: A frame has 1066 lines: 1024 visible, 1 front porch, 3 sync, 38 back porch. `vsync_o` is active high during lines 1025 to 1027 and is registered like `hsync_o`.
- R4: `req_valid_o` is high for exactly one clock, at column 1280 of every line whose successor is visible. On the last line of the frame it requests line 0. No request is made in any other cycle.
- R5: `fifo_pop_o` is high for one clock at each visible column that is a multiple of 12. That gives 107 pops per visible line and none during blanking.
- R6: In a popped word, bits [4:0] are the first pixel, [9:5] the second and [14:10] the third. Bits [30:15] are ignored. Each pixel is shown for 4 consecutive columns.
- R7: `req_addr_o` equals (L/4)*107, where L is the line being requested. Each source line is therefore fetched for 4 consecutive output lines.
- R8: Palette. Pixel bit 0 enables red, bit 1 green and bit 2 blue. An enabled channel outputs 0x5 if bit 4 is set, otherwise 0xF if bit 3 is set, otherwise 0xA. A disabled channel outputs 0.
- R9: Red, green and blue outputs are 0 for every column or line outside the visible area.
- R10: The word is taken from `fifo_word_i` in the same cycle that `fifo_pop_o` is high. Its first pixel's colour appears on the outputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 108 MHz pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_o | output | 1 | One-cycle source-line fetch request |
| req_addr_o | output | 16 | Word address of the requested source line |
| fifo_pop_o | output | 1 | Pop strobe to the line FIFO |
| fifo_word_i | input | 31 | Head word of the line FIFO, valid in the pop cycle |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| red_o | output | 4 | Red level |
| green_o | output | 4 | Green level |
| blue_o | output | 4 | Blue level |

## Verification
The bench runs the design with shortened porches and a 14-pixel source width. This makes the last word of a line carry only two used pixels. A design that counted whole words would then pop one word too many or too few, which shifts every following line's fetch and garbles the picture. The bench models the FIFO as a pointer into a memory filled from a per-address hash. A wrong request address, a missing re-fetch per output line or a mis-ordered pixel slot therefore shows up as a colour mismatch, not as a silent repeat. Frame wrap-around is exercised, where the last line must request line 0. So is a reset in the middle of a line, which a design with a synchronous reset or a stale word register would not clear at once.

// File: rtl/scl_pkg.sv
package scl_pkg;

  localparam int PIX_W = 5;
  localparam int COL_W = 4;

  // roles of the bits inside one source pixel
  localparam int BIT_R  = 0;
  localparam int BIT_G  = 1;
  localparam int BIT_B  = 2;
  localparam int BIT_HI = 3;
  localparam int BIT_LO = 4;

  localparam logic [COL_W-1:0] LVL_OFF = 4'h0;
  localparam logic [COL_W-1:0] LVL_DIM = 4'h5;
  localparam logic [COL_W-1:0] LVL_MID = 4'hA;
  localparam logic [COL_W-1:0] LVL_TOP = 4'hF;

  typedef struct packed {
    logic [COL_W-1:0] r;
    logic [COL_W-1:0] g;
    logic [COL_W-1:0] b;
  } rgb_t;

  function automatic logic [COL_W-1:0] level(input logic on, input logic [PIX_W-1:0] p);
    logic [COL_W-1:0] l;
    if (!on)           l = LVL_OFF;
    else if (p[BIT_LO]) l = LVL_DIM;
    else if (p[BIT_HI]) l = LVL_TOP;
    else               l = LVL_MID;
    return l;
  endfunction

  function automatic rgb_t palette(input logic [PIX_W-1:0] p);
    rgb_t c;
    c.r = level(p[BIT_R], p);
    c.g = level(p[BIT_G], p);
    c.b = level(p[BIT_B], p);
    return c;
  endfunction

endpackage

// File: rtl/scl_timing.sv
module scl_timing #(
  parameter int H_VIS  = 1280,
  parameter int H_FP   = 48,
  parameter int H_SYNC = 112,
  parameter int H_BP   = 248,
  parameter int V_VIS  = 1024,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 3,
  parameter int V_BP   = 38,
  parameter int PH_LEN = 12,
  parameter int HW     = 11,
  parameter int VW     = 11,
  parameter int PW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic [PW-1:0] ph_o,
  output logic          vis_o,
  output logic          hs_o,
  output logic          vs_o
);

  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_VIS + V_FP + V_SYNC);
  localparam logic [PW-1:0] PH_LAST = PW'(PH_LEN - 1);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    h_d  = h_q + HW'(1);
    v_d  = v_q;
    ph_d = (ph_q == PH_LAST) ? '0 : ph_q + PW'(1);
    if (h_q == H_LAST) begin
      h_d  = '0;
      ph_d = '0;
      v_d  = (v_q == V_LAST) ? '0 : v_q + VW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q  <= '0;
      v_q  <= '0;
      ph_q <= '0;
    end else begin
      h_q  <= h_d;
      v_q  <= v_d;
      ph_q <= ph_d;
    end
  end

  assign h_o   = h_q;
  assign v_o   = v_q;
  assign ph_o  = ph_q;
  assign vis_o = (h_q < HW'(H_VIS)) && (v_q < VW'(V_VIS));
  assign hs_o  = (h_q >= HS_BEG) && (h_q < HS_END);
  assign vs_o  = (v_q >= VS_BEG) && (v_q < VS_END);

endmodule

// File: rtl/scl_fetch.sv
module scl_fetch #(
  parameter int H_VIS  = 1280,
  parameter int V_VIS  = 1024,
  parameter int V_TOT  = 1066,
  parameter int SCALE  = 4,
  parameter int WPL    = 107,
  parameter int ADDR_W = 16,
  parameter int HW     = 11,
  parameter int VW     = 11
) (
  input  logic              run_i,
  input  logic [HW-1:0]     h_i,
  input  logic [VW-1:0]     v_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int SH = $clog2(SCALE);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);

  logic [VW-1:0] next_line;
  logic [VW-1:0] src_line;
  logic [31:0]   prod;

  always_comb begin
    next_line = (v_i == V_LAST) ? '0 : v_i + VW'(1);
    src_line  = next_line >> SH;
    prod      = 32'(src_line) * 32'(WPL);
    addr_o    = prod[ADDR_W-1:0];
    req_o     = run_i && (h_i == HW'(H_VIS)) && (next_line < VW'(V_VIS));
  end

endmodule

// File: rtl/scl_pixel.sv
module scl_pixel
  import scl_pkg::*;
#(
  parameter int PPW   = 3,
  parameter int SCALE = 4,
  parameter int PW    = 4,
  localparam int PK_W = PPW * PIX_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            vis_i,
  input  logic [PW-1:0]   ph_i,
  input  logic            hs_i,
  input  logic            vs_i,
  input  logic [PK_W-1:0] word_i,
  output logic            pop_o,
  output logic            hs_o,
  output logic            vs_o,
  output rgb_t            rgb_o
);

  localparam int SH = $clog2(SCALE);

  logic [PK_W-1:0]  word_q, word_d;
  logic [PK_W-1:0]  cur_word;
  logic [PIX_W-1:0] slot [PPW];
  logic [PIX_W-1:0] pix;
  logic [PW-1:0]    sel;
  logic             pop;
  rgb_t             rgb_d;

  assign pop      = run_i && vis_i && (ph_i == '0);
  assign cur_word = pop ? word_i : word_q;
  assign sel      = ph_i >> SH;

  for (genvar g = 0; g < PPW; g++) begin : g_slot
    assign slot[g] = cur_word[g*PIX_W +: PIX_W];
  end

  always_comb begin
    pix = '0;
    for (int i = 0; i < PPW; i++) begin
      if (sel == PW'(i)) pix = slot[i];
    end
    rgb_d  = vis_i ? palette(pix) : '0;
    word_d = word_q;
    if (pop) word_d = word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      rgb_o  <= '0;
    end else begin
      word_q <= word_d;
      hs_o   <= hs_i;
      vs_o   <= vs_i;
      rgb_o  <= rgb_d;
    end
  end

  assign pop_o = pop;

endmodule

// File: rtl/scl_vga_out.sv
module scl_vga_out
  import scl_pkg::*;
#(
  parameter int H_VIS  = 1280,
  parameter int H_FP   = 48,
  parameter int H_SYNC = 112,
  parameter int H_BP   = 248,
  parameter int V_VIS  = 1024,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 3,
  parameter int V_BP   = 38,
  parameter int SCALE  = 4,
  parameter int PPW    = 3,
  parameter int ADDR_W = 16,
  localparam int WORD_W = PPW * PIX_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              fifo_pop_o,
  input  logic [WORD_W-1:0] fifo_word_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [COL_W-1:0]  red_o,
  output logic [COL_W-1:0]  green_o,
  output logic [COL_W-1:0]  blue_o
);

  localparam int H_TOT  = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT  = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int SRC_W  = H_VIS / SCALE;
  localparam int WPL    = (SRC_W + PPW - 1) / PPW;
  localparam int PH_LEN = SCALE * PPW;
  localparam int PK_W   = PPW * PIX_W;
  localparam int HW     = $clog2(H_TOT);
  localparam int VW     = $clog2(V_TOT);
  localparam int PW     = $clog2(PH_LEN);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic [PW-1:0] phase;
  logic          vis;
  logic          hs_raw;
  logic          vs_raw;
  rgb_t          rgb;
  logic          unused_addr_bits;

  assign unused_addr_bits = ^fifo_word_i[WORD_W-1:PK_W];

  scl_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .PH_LEN(PH_LEN), .HW(HW), .VW(VW), .PW(PW)
  ) u_timing (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .h_o   (h_cnt),
    .v_o   (v_cnt),
    .ph_o  (phase),
    .vis_o (vis),
    .hs_o  (hs_raw),
    .vs_o  (vs_raw)
  );

  scl_fetch #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .V_TOT(V_TOT), .SCALE(SCALE),
    .WPL(WPL), .ADDR_W(ADDR_W), .HW(HW), .VW(VW)
  ) u_fetch (
    .run_i (rst_sync_n),
    .h_i   (h_cnt),
    .v_i   (v_cnt),
    .req_o (req_valid_o),
    .addr_o(req_addr_o)
  );

  scl_pixel #(
    .PPW(PPW), .SCALE(SCALE), .PW(PW)
  ) u_pixel (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .run_i (rst_sync_n),
    .vis_i (vis),
    .ph_i  (phase),
    .hs_i  (hs_raw),
    .vs_i  (vs_raw),
    .word_i(fifo_word_i[PK_W-1:0]),
    .pop_o (fifo_pop_o),
    .hs_o  (hsync_o),
    .vs_o  (vsync_o),
    .rgb_o (rgb)
  );

  assign red_o   = rgb.r;
  assign green_o = rgb.g;
  assign blue_o  = rgb.b;

endmodule

// File: rtl/scl_vga_out_chk.sv
module scl_vga_out_chk #(
  parameter int H_VIS = 1280,
  parameter int H_FP  = 48,
  parameter int HW    = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [HW-1:0] h_cnt,
  input logic          vis,
  input logic          fifo_pop_o,
  input logic          req_valid_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic [3:0]    red_o,
  input logic [3:0]    green_o,
  input logic [3:0]    blue_o
);

  AST_POP_IN_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> vis); // R5

  AST_POP_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o); // R5

  AST_REQ_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !vis); // R4

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o); // R4

  AST_BLANK_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({red_o, green_o, blue_o} != 12'h000) |-> $past(vis)); // R9

  AST_HSYNC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> (h_cnt == HW'(H_VIS + H_FP + 1))); // R2

  AST_VSYNC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> (h_cnt == HW'(1))); // R3

endmodule

bind scl_vga_out scl_vga_out_chk #(
  .H_VIS(H_VIS), .H_FP(H_FP), .HW(HW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .h_cnt      (h_cnt),
  .vis        (vis),
  .fifo_pop_o (fifo_pop_o),
  .req_valid_o(req_valid_o),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .red_o      (red_o),
  .green_o    (green_o),
  .blue_o     (blue_o)
);

// File: tb/test_scl_vga_out.sv
`timescale 1ns/1ps
module test_scl_vga_out;

  // shortened raster: 14 source pixels per line -> 5 words, last one half used
  localparam int HV = 56, HF = 4, HS = 6, HB = 10, HT = HV + HF + HS + HB;
  localparam int VV = 16, VF = 1, VS = 3, VB = 4,  VT = VV + VF + VS + VB;
  localparam int WPL = 5;
  localparam int FRAME = HT * VT;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_addr;
  logic        fifo_pop;
  logic [30:0] fifo_word;
  logic        hsync, vsync;
  logic [3:0]  red, green, blue;

  scl_vga_out #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) i_scl_vga_out (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_o(req_valid), .req_addr_o(req_addr),
    .fifo_pop_o(fifo_pop), .fifo_word_i(fifo_word),
    .hsync_o(hsync), .vsync_o(vsync),
    .red_o(red), .green_o(green), .blue_o(blue)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory content: hash of the word address, upper bits are filler
  function automatic logic [30:0] gen(input int a);
    logic [31:0] x;
    x = a * 32'h9E3779B1 + 32'h01234567;
    x = x ^ (x >> 13);
    x = x * 32'h85EBCA6B;
    return x[30:0];
  endfunction

  function automatic int chan(input int p, input int bitpos);
    if (((p >> bitpos) & 1) == 0) return 0;
    if ((p & 16) != 0) return 5;
    if ((p & 8) != 0)  return 15;
    return 10;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // FIFO stand-in: pointer into the hashed memory
  int base, idx;
  assign fifo_word = gen(base + idx);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= 0;
      idx  <= 0;
    end else if (req_valid) begin
      base <= int'(req_addr);
      idx  <= 0;
    end else if (fifo_pop) begin
      idx <= idx + 1;
    end
  end

  // reference raster
  int k, mh, mv;
  int e_hs, e_vs, e_r, e_g, e_b, e_vis;
  int w, p;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k <= 0; mh <= 0; mv <= 0;
      e_hs <= 0; e_vs <= 0; e_r <= 0; e_g <= 0; e_b <= 0; e_vis <= 0;
    end else begin
      if (k >= 2) begin
        e_hs  <= (mh >= HV + HF && mh < HV + HF + HS) ? 1 : 0;
        e_vs  <= (mv >= VV + VF && mv < VV + VF + VS) ? 1 : 0;
        e_vis <= (mh < HV && mv < VV) ? 1 : 0;
        if (mh < HV && mv < VV) begin
          w = int'(gen((mv / 4) * WPL + mh / 12));
          p = (w >> (5 * ((mh % 12) / 4))) & 31;
          e_r <= chan(p, 0);
          e_g <= chan(p, 1);
          e_b <= chan(p, 2);
        end else begin
          e_r <= 0; e_g <= 0; e_b <= 0;
        end
        if (mh == HT - 1) begin
          mh <= 0;
          mv <= (mv == VT - 1) ? 0 : mv + 1;
        end else begin
          mh <= mh + 1;
        end
      end
      if (k < 8) k <= k + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int nl, pop_e, req_e;
      string t_out;
      nl    = (mv == VT - 1) ? 0 : mv + 1;
      pop_e = (rst_n && k >= 2 && mv < VV && mh < HV && (mh % 12) == 0) ? 1 : 0;
      req_e = (rst_n && k >= 2 && mh == HV && nl < VV) ? 1 : 0;
      if (!rst_n || k < 3) begin
        chk("R1", "hsync", int'(hsync), 0);
        chk("R1", "vsync", int'(vsync), 0);
        chk("R1", "rgb", int'({red, green, blue}), 0);
      end else begin
        chk("R2", "hsync", int'(hsync), e_hs);
        chk("R3", "vsync", int'(vsync), e_vs);
        t_out = (e_vis != 0) ? "R6 R8 R10" : "R9";
        chk(t_out, "red", int'(red), e_r);
        chk(t_out, "green", int'(green), e_g);
        chk(t_out, "blue", int'(blue), e_b);
      end
      chk("R5", "fifo_pop", int'(fifo_pop), pop_e);
      chk("R4", "req_valid", int'(req_valid), req_e);
      if (req_e != 0 && req_valid)
        chk("R4 R7", "req_addr", int'(req_addr), (nl / 4) * WPL);
    end
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // three full frames, wrap-around included
    repeat (3 * FRAME + 150) @(posedge clk);
    // reset in the middle of a line
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (FRAME + 300) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule